// File: doc/BRIEF.md
# Splittable Pipelined Integer Multiplier

This block is a two-stage pipelined integer multiplier for a pixel-oriented data path. It works in one of two modes, chosen per operation. In full mode it multiplies the low 16 bits of each 32-bit operand and returns the whole 32-bit product. The operands are read as unsigned or as two's complement, as the sign select asks. In split mode the same array of partial products is divided along byte lanes. It returns two independent unsigned 8x8 products packed side by side, so one issue slot gives two pixel products.

The mode comes from a 2-bit size field. The byte code selects split mode and any other code selects full mode. The size field, the sign select and the operands are all captured together when the valid strobe is high. Back-to-back operations can therefore change mode on every cycle. Results appear two clock edges after issue, and a new operation can be accepted on every cycle.

Top module: `smul_top`

## Requirements
- R1: `size_i == 2'b00` selects split mode. The codes 2'b01, 2'b10 and 2'b11 all select full mode.
- R2: In split mode, `result_o[15:0]` is the unsigned product `a_i[7:0] * b_i[7:0]` and `result_o[31:16]` is the unsigned product `a_i[15:8] * b_i[15:8]`. The two lanes do not affect each other.
- R3: In full mode with `unsigned_i = 1`, `result_o` is the unsigned 32-bit product `a_i[15:0] * b_i[15:0]`.
- R4: In full mode with `unsigned_i = 0`, `result_o` is the two's-complement 32-bit product of `a_i[15:0]` and `b_i[15:0]`, both read as signed.
- R5: An operation issued with `valid_i = 1` before rising edge N drives `valid_o = 1` with its result after rising edge N+1. `valid_o` is 0 in cycles that follow no issue. One operation is accepted per cycle.
- R6: Operand bits 31:16 have no effect on the result in either mode.
- R7: `unsigned_i` has no effect in split mode.
- R8: Mode and sign are captured per operation. Back-to-back operations that use different modes each return the result of their own mode.
- R9: While `rst_ni` is low, and in the first cycle after its release with no issue, `valid_o = 0` and `result_o = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe; operands and controls are captured when high |
| size_i | input | 2 | Size field; 2'b00 = byte (split mode), other codes = full mode |
| unsigned_i | input | 1 | 1 = unsigned, 0 = signed (full mode only) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Product, or two packed byte-lane products |

## Verification
On every issued operation, the assertions compare the result two edges later against a port-level product model. This holds for each byte lane in split mode and for the unsigned and signed full-mode products. The assertions also follow the valid bit through both stages and check that split-mode partial products never overflow their lane. Only the bench's scenarios show the effects that span several operations or need chosen data. These are the reset values, that upper operand bits and the sign select are ignored, that cross-lane carries are absent in split mode, and that mode changes between back-to-back issues are handled.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // byte lanes per 16-bit multiplier half
  localparam int unsigned NUM_LANES = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  function automatic logic is_byte_size(input logic [1:0] size);
    return size == SZ_BYTE;
  endfunction

endpackage

// File: rtl/smul_lane_mul.sv
module smul_lane_mul #(
  parameter  int unsigned LANE_W = 8,
  localparam int unsigned PP_W   = 2*LANE_W + 2
) (
  input  logic [LANE_W:0] a_i,
  input  logic [LANE_W:0] b_i,
  output logic [PP_W-1:0] p_o
);

  // lane operands arrive extended by one bit: zero for unsigned, sign for signed top lane
  logic signed [PP_W-1:0] a_sx, b_sx;

  assign a_sx = PP_W'($signed(a_i));
  assign b_sx = PP_W'($signed(b_i));
  assign p_o  = a_sx * b_sx;

endmodule

// File: rtl/smul_pp_stage.sv
module smul_pp_stage
  import smul_pkg::*;
#(
  parameter  int unsigned LANE_W = 8,
  localparam int unsigned OP_W   = NUM_LANES*LANE_W,
  localparam int unsigned PP_W   = 2*LANE_W + 2,
  localparam int unsigned NUM_PP = NUM_LANES*NUM_LANES
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        split_i,
  input  logic                        signed_i,
  input  logic [OP_W-1:0]             a_i,
  input  logic [OP_W-1:0]             b_i,
  output logic                        valid_o,
  output logic                        split_o,
  output logic [NUM_PP-1:0][PP_W-1:0] pp_o
);

  logic [NUM_LANES-1:0][LANE_W:0] a_ext, b_ext;
  logic [NUM_PP-1:0][PP_W-1:0]    pp_d;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_ext
    if (l == NUM_LANES-1) begin : g_top
      assign a_ext[l] = {signed_i & a_i[OP_W-1], a_i[l*LANE_W +: LANE_W]};
      assign b_ext[l] = {signed_i & b_i[OP_W-1], b_i[l*LANE_W +: LANE_W]};
    end else begin : g_low
      assign a_ext[l] = {1'b0, a_i[l*LANE_W +: LANE_W]};
      assign b_ext[l] = {1'b0, b_i[l*LANE_W +: LANE_W]};
    end
  end

  // pp index = a_lane*NUM_LANES + b_lane; diagonal entries are the split-mode lanes
  for (genvar ia = 0; ia < NUM_LANES; ia++) begin : g_row
    for (genvar ib = 0; ib < NUM_LANES; ib++) begin : g_col
      smul_lane_mul #(.LANE_W(LANE_W)) i_mul (
        .a_i (a_ext[ia]),
        .b_i (b_ext[ib]),
        .p_o (pp_d[ia*NUM_LANES+ib])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      split_o <= 1'b0;
      pp_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        split_o <= split_i;
        pp_o    <= pp_d;
      end
    end
  end

  // R5: issue reaches stage 1 on the next edge
  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2: split issues are never signed
  p_split_unsigned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && split_i) |-> !signed_i);

  // R2: split-lane products fit their 16-bit lane
  p_split_fit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && split_o) |->
      (pp_o[0][PP_W-1 -: 2] == 2'b00 && pp_o[NUM_PP-1][PP_W-1 -: 2] == 2'b00));

endmodule

// File: rtl/smul_sum_stage.sv
module smul_sum_stage
  import smul_pkg::*;
#(
  parameter  int unsigned LANE_W = 8,
  localparam int unsigned OP_W   = NUM_LANES*LANE_W,
  localparam int unsigned RES_W  = 2*OP_W,
  localparam int unsigned PP_W   = 2*LANE_W + 2,
  localparam int unsigned NUM_PP = NUM_LANES*NUM_LANES
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        split_i,
  input  logic [NUM_PP-1:0][PP_W-1:0] pp_i,
  output logic                        valid_o,
  output logic [RES_W-1:0]            result_o
);

  function automatic logic [RES_W-1:0] sext(input logic [PP_W-1:0] v);
    return {{(RES_W-PP_W){v[PP_W-1]}}, v};
  endfunction

  logic [RES_W-1:0] full_d, split_d, res_d;

  always_comb begin
    full_d  = '0;
    split_d = '0;
    for (int ia = 0; ia < NUM_LANES; ia++) begin
      for (int ib = 0; ib < NUM_LANES; ib++) begin
        full_d = full_d + (sext(pp_i[ia*NUM_LANES+ib]) << ((ia+ib)*LANE_W));
      end
      // cross terms dropped: each lane keeps only its own diagonal product
      split_d[ia*2*LANE_W +: 2*LANE_W] = pp_i[ia*NUM_LANES+ia][2*LANE_W-1:0];
    end
    res_d = split_i ? split_d : full_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end

  // R5: stage 2 valid follows stage 1 exactly
  p_emit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

endmodule

// File: rtl/smul_top.sv
module smul_top
  import smul_pkg::*;
#(
  parameter  int unsigned LANE_W = 8,
  localparam int unsigned OP_W   = NUM_LANES*LANE_W,
  localparam int unsigned DATA_W = 2*OP_W,
  localparam int unsigned PP_W   = 2*LANE_W + 2,
  localparam int unsigned NUM_PP = NUM_LANES*NUM_LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);

  logic                        split_op, signed_op;
  logic                        s1_valid, s1_split;
  logic [NUM_PP-1:0][PP_W-1:0] s1_pp;
  logic                        unused_hi;

  assign split_op  = is_byte_size(size_i);
  assign signed_op = !unsigned_i && !split_op;
  assign unused_hi = ^{a_i[DATA_W-1:OP_W], b_i[DATA_W-1:OP_W]};

  smul_pp_stage #(.LANE_W(LANE_W)) i_pp_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .split_i  (split_op),
    .signed_i (signed_op),
    .a_i      (a_i[OP_W-1:0]),
    .b_i      (b_i[OP_W-1:0]),
    .valid_o  (s1_valid),
    .split_o  (s1_split),
    .pp_o     (s1_pp)
  );

  smul_sum_stage #(.LANE_W(LANE_W)) i_sum_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid),
    .split_i  (s1_split),
    .pp_i     (s1_pp),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  // port-level reference operands for the checks below
  logic [OP_W-1:0]   chk_a0, chk_b0, chk_a1, chk_b1;
  logic [DATA_W-1:0] chk_a_zx, chk_b_zx, chk_a_sx, chk_b_sx;

  assign chk_a0   = OP_W'(a_i[LANE_W-1:0]);
  assign chk_b0   = OP_W'(b_i[LANE_W-1:0]);
  assign chk_a1   = OP_W'(a_i[2*LANE_W-1:LANE_W]);
  assign chk_b1   = OP_W'(b_i[2*LANE_W-1:LANE_W]);
  assign chk_a_zx = DATA_W'(a_i[OP_W-1:0]);
  assign chk_b_zx = DATA_W'(b_i[OP_W-1:0]);
  assign chk_a_sx = DATA_W'($signed(a_i[OP_W-1:0]));
  assign chk_b_sx = DATA_W'($signed(b_i[OP_W-1:0]));

  p_split_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && split_op) |=> ##1
      (valid_o && result_o[OP_W-1:0] == OP_W'($past(chk_a0, 2) * $past(chk_b0, 2))));

  p_split_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && split_op) |=> ##1
      (valid_o && result_o[DATA_W-1:OP_W] == OP_W'($past(chk_a1, 2) * $past(chk_b1, 2))));

  p_full_unsigned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !split_op && unsigned_i) |=> ##1
      (valid_o && result_o == DATA_W'($past(chk_a_zx, 2) * $past(chk_b_zx, 2))));

  p_full_signed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !split_op && !unsigned_i) |=> ##1
      (valid_o && result_o == DATA_W'($past(chk_a_sx, 2) * $past(chk_b_sx, 2))));

  // R5: output valid only behind a stage-1 valid
  p_valid_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(s1_valid));

endmodule

// File: tb/test_smul_top.sv
module test_smul_top;
  import smul_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [1:0]  sz;
    logic        uns;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'b01, 1'b1, 32'h0000_0003, 32'h0000_0005, 32'h0000_000F},
    '{2'b01, 1'b1, 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFE_0001},
    '{2'b01, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0001},
    '{2'b01, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000},
    '{2'b01, 1'b0, 32'h0000_8000, 32'h0000_0001, 32'hFFFF_8000},
    '{2'b01, 1'b0, 32'h0000_7FFF, 32'h0000_8000, 32'hC000_8000},
    '{2'b00, 1'b1, 32'h0000_FF02, 32'h0000_FF03, 32'hFE01_0006},
    '{2'b00, 1'b0, 32'hABCD_FF02, 32'h1234_FF03, 32'hFE01_0006},
    '{2'b10, 1'b1, 32'h1234_0010, 32'hFFFF_0010, 32'h0000_0100},
    '{2'b11, 1'b0, 32'h0000_0002, 32'h0000_FFFE, 32'hFFFF_FFFC},
    '{2'b00, 1'b1, 32'h0000_1080, 32'h0000_0402, 32'h0040_0100},
    '{2'b01, 1'b1, 32'h0000_1080, 32'h0000_0402, 32'h0042_2100}
  };

  string vec_tag [NV] = '{
    "R3 small", "R3 max unsigned", "R4 minus one squared", "R4 min squared",
    "R4 min times one", "R4 max times min", "R2 lanes", "R7 R6 split ignores sign and upper bits",
    "R1 R6 size 2'b10 full", "R1 size 2'b11 full signed", "R2 no cross-lane terms",
    "R8 same operands full after split"
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic [1:0]  size;
  logic        uns;
  logic [31:0] a, b;
  logic        valid_o;
  logic [31:0] result_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smul_top i_smul_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .valid_i    (valid),
    .size_i     (size),
    .unsigned_i (uns),
    .a_i        (a),
    .b_i        (b),
    .valid_o    (valid_o),
    .result_o   (result_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] s, input logic u, input logic [31:0] va, input logic [31:0] vb);
    valid = 1'b1; size = s; uns = u; a = va; b = vb;
  endtask

  initial begin
    rst_n = 1'b0;
    issue(2'b01, 1'b1, 32'h0000_0009, 32'h0000_0009);
    repeat (3) @(negedge clk);
    check("R9 valid during reset", {31'b0, valid_o}, 32'h0);
    check("R9 result during reset", result_o, 32'h0);
    valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 valid after release", {31'b0, valid_o}, 32'h0);
    check("R9 result after release", result_o, 32'h0);

    // R5 isolated latency
    issue(2'b01, 1'b1, 32'h0000_0007, 32'h0000_0006);
    @(negedge clk);
    valid = 1'b0;
    check("R5 not valid after one edge", {31'b0, valid_o}, 32'h0);
    @(negedge clk);
    check("R5 valid after two edges", {31'b0, valid_o}, 32'h1);
    check("R5 result after two edges", result_o, 32'd42);
    @(negedge clk);
    check("R5 single pulse", {31'b0, valid_o}, 32'h0);

    // back-to-back stream, one issue per cycle (R5, R8)
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        check({vec_tag[i-2], " valid"}, {31'b0, valid_o}, 32'h1);
        check(vec_tag[i-2], result_o, VEC[i-2].exp);
      end
      if (i < NV) issue(VEC[i].sz, VEC[i].uns, VEC[i].a, VEC[i].b);
      else valid = 1'b0;
      @(negedge clk);
    end
    check("R5 valid drops after stream", {31'b0, valid_o}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule